// File: doc/BRIEF.md
# Cyclic Four-Phase Timestamp Latch

This block watches a serial protocol engine from the side and follows its progress through a ring of four phases, numbered 0 to 3. Each phase step has its own rule. The rule combines five monitored inputs: the engine's instruction pointer, the line clock, the transmit data, the receive data and a timeout flag. Each input is tested against a two-bit condition code, and each test can be switched off by itself. A step is taken only when every test that is switched on holds in the same clock cycle.

When the ring closes, on the step from phase 3 back to phase 0, a programmable delay starts. When the delay runs out, the block copies a free-running timestamp into a holding register. In that same cycle it raises a one-cycle event flag and pulses one selected trigger line. Integrators use the block to timestamp points in a frame, such as the end of a reply, without software in the loop.

Top module: `seq_stamp_latch`

## Requirements
- R1: While `rstN` is low, and after it is released, `curState` is 0, `latchTime` is 0, `latchEvent` is 0 and `trigOut` is 0.
- R2: The phase moves only along 0→1→2→3→0, by at most one step per clock. Step t leaves phase t. It is taken at a clock edge where `cfgEnable` is 1 and all the conditions of step t hold. The new phase is visible on `curState` after that edge.
- R3: Each step t has five checks, with index c: 0 = pointer, 1 = clock, 2 = transmit, 3 = receive, 4 = timeout. Bit `cfgChkDis[t*5+c]`=1 turns a check off, and a check that is off counts as true. A step needs every check that is on to be true in the same cycle. With every check off, the phase advances on every clock.
- R4: Level codes, held in `cfgCond[(t*5+c)*2 +: 2]`: code 0 holds while the signal is 1, and code 1 holds while it is 0.
- R5: Edge codes are judged against the value the signal had at the previous clock edge. Code 2 holds when the signal is now 1 and was 0. Code 3 holds when it is now 0 and was 1. A signal that stays high or stays low never meets an edge code.
- R6: The pointer check compares `instrPtr` with the 8-bit value `cfgPtrVal[t*8 +: 8]` of step t. Code 0 means the two are equal, and code 1 means they differ. Code 2 means they are equal now but differed at the previous edge (just entered). Code 3 means they differ now but were equal at the previous edge (just left).
- R7: Only the step from 3 to 0 starts a capture. With delay D = `cfgDelay`, the capture happens at the (D+1)-th clock edge after the edge that took the step. `latchTime` takes the `timeNow` value that edge sees, and it holds its value at every other time.
- R8: In the cycle after a capture edge, `latchEvent` is 1 for exactly one cycle. In that same cycle `trigOut` has only bit `cfgOutSel` set. At all other times `trigOut` is 0.
- R9: If a new 3→0 step happens while a capture is still waiting, the delay restarts from that step, and the earlier deadline produces no capture.
- R10: While `cfgEnable` is 0, the phase is forced to 0 at each edge, any waiting capture is cancelled, `latchEvent` and `trigOut` stay 0, and `latchTime` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Unit enable |
| cfgDelay | input | 16 | Clocks of delay, counted after the closing step |
| cfgOutSel | input | 2 | Index of the trigger line to pulse |
| cfgCond | input | 40 | Condition codes, 2 bits for each step and check |
| cfgChkDis | input | 20 | Disable bit for each step and check |
| cfgPtrVal | input | 32 | Pointer compare value, 8 bits for each step |
| instrPtr | input | 8 | Live instruction pointer |
| sigClk | input | 1 | Monitored line clock |
| sigTxd | input | 1 | Monitored transmit data |
| sigRxd | input | 1 | Monitored receive data |
| sigTimeout | input | 1 | Monitored timeout flag |
| timeNow | input | 32 | Free-running timestamp |
| curState | output | 2 | Current phase |
| latchTime | output | 32 | Captured timestamp |
| latchEvent | output | 1 | One-cycle capture flag |
| trigOut | output | 4 | Trigger lines, one-hot pulse at capture |

## Verification
A phase step shows on `curState` one edge after the edge that sees its conditions true. A capture shows on `latchTime`, `latchEvent` and `trigOut` D+1 edges after the closing step. The bench changes inputs on falling edges, and it reads the timestamp expected by a capture just before the edge that should capture it. Each check sits at the falling edge after that edge. For the delay and restart cases, every earlier falling edge is also checked to confirm that no event appears early or at the cancelled deadline.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int NUM_STATES = 4;
  localparam int STATE_W    = $clog2(NUM_STATES);
  localparam int NUM_CHK    = 5;
  localparam int CODE_W     = 2;
  localparam int CHK_PTR    = 0;

  typedef logic [STATE_W-1:0] stateIdx_t;

  typedef struct packed {
    logic capture;
  } sslStrobe_t;

  // Evaluate one condition code against a current and a previous truth value.
  function automatic logic condHit(input logic [CODE_W-1:0] code,
                                   input logic cur, input logic prev);
    logic hit;
    case (code)
      2'd0:    hit = cur;
      2'd1:    hit = !cur;
      2'd2:    hit = cur && !prev;
      default: hit = !cur && prev;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/ssl_sense.sv
module ssl_sense
  import ssl_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [PTR_W-1:0]                      instrPtr,
  input  logic                                  sigClk,
  input  logic                                  sigTxd,
  input  logic                                  sigRxd,
  input  logic                                  sigTimeout,
  input  logic [NUM_STATES*NUM_CHK*CODE_W-1:0]  cfgCond,
  input  logic [NUM_STATES*NUM_CHK-1:0]         cfgChkDis,
  input  logic [NUM_STATES*PTR_W-1:0]           cfgPtrVal,
  output logic [NUM_STATES-1:0]                 goMask
);
  localparam int NUM_LINES = NUM_CHK - 1;

  logic [NUM_LINES-1:0] liveLines;
  logic [NUM_LINES-1:0] prevLines;
  logic [PTR_W-1:0]     prevPtr;

  assign liveLines = {sigTimeout, sigRxd, sigTxd, sigClk};

  // History of every monitored input, one clock behind.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLines <= '0;
      prevPtr   <= '0;
    end else begin
      prevLines <= liveLines;
      prevPtr   <= instrPtr;
    end
  end

  for (genvar t = 0; t < NUM_STATES; t++) begin : gStep
    logic [NUM_CHK-1:0] curVal;
    logic [NUM_CHK-1:0] oldVal;
    logic [NUM_CHK-1:0] okVec;
    logic [PTR_W-1:0]   refPtr;

    assign refPtr                  = cfgPtrVal[t*PTR_W +: PTR_W];
    assign curVal[CHK_PTR]         = (instrPtr == refPtr);
    assign oldVal[CHK_PTR]         = (prevPtr == refPtr);
    assign curVal[NUM_CHK-1:1]     = liveLines;
    assign oldVal[NUM_CHK-1:1]     = prevLines;

    for (genvar c = 0; c < NUM_CHK; c++) begin : gChk
      assign okVec[c] = cfgChkDis[t*NUM_CHK + c] ||
                        condHit(cfgCond[(t*NUM_CHK + c)*CODE_W +: CODE_W],
                                curVal[c], oldVal[c]);
    end

    assign goMask[t] = &okVec;
  end
endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
  import ssl_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEnable,
  input  logic [DLY_W-1:0]      cfgDelay,
  input  logic [NUM_STATES-1:0] goMask,
  output stateIdx_t             curState,
  output sslStrobe_t            strobe
);
  localparam stateIdx_t LAST_STATE = stateIdx_t'(NUM_STATES - 1);

  logic             stepNow;
  logic             ringClose;
  logic             pending;
  logic [DLY_W-1:0] dlyCnt;

  assign stepNow   = cfgEnable && goMask[curState];
  assign ringClose = stepNow && (curState == LAST_STATE);

  // A new ring closure takes priority over an expiring older deadline.
  assign strobe.capture = cfgEnable && pending && (dlyCnt == '0) && !ringClose;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= '0;
      pending  <= 1'b0;
      dlyCnt   <= '0;
    end else if (!cfgEnable) begin
      curState <= '0;
      pending  <= 1'b0;
      dlyCnt   <= '0;
    end else begin
      if (stepNow) begin
        curState <= stateIdx_t'(curState + 1'b1);
      end
      if (ringClose) begin
        pending <= 1'b1;
        dlyCnt  <= cfgDelay;
      end else if (pending) begin
        if (dlyCnt == '0) begin
          pending <= 1'b0;
        end else begin
          dlyCnt <= dlyCnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssl_datapath.sv
module ssl_datapath
  import ssl_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int OUT_N = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  sslStrobe_t       strobe,
  input  logic [TS_W-1:0]  timeNow,
  input  logic [SEL_W-1:0] cfgOutSel,
  output logic [TS_W-1:0]  latchTime,
  output logic             latchEvent,
  output logic [OUT_N-1:0] trigOut
);
  logic [OUT_N-1:0] selOneHot;

  always_comb begin
    selOneHot = '0;
    for (int i = 0; i < OUT_N; i++) begin
      if (cfgOutSel == SEL_W'(i)) selOneHot[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchTime  <= '0;
      latchEvent <= 1'b0;
      trigOut    <= '0;
    end else begin
      latchEvent <= strobe.capture;
      trigOut    <= strobe.capture ? selOneHot : '0;
      if (strobe.capture) begin
        latchTime <= timeNow;
      end
    end
  end
endmodule

// File: rtl/seq_stamp_latch.sv
module seq_stamp_latch
  import ssl_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int TS_W  = 32,
  parameter int DLY_W = 16,
  parameter int OUT_N = 4,
  localparam int SEL_W = (OUT_N > 1) ? $clog2(OUT_N) : 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cfgEnable,
  input  logic [DLY_W-1:0]                     cfgDelay,
  input  logic [SEL_W-1:0]                     cfgOutSel,
  input  logic [NUM_STATES*NUM_CHK*CODE_W-1:0] cfgCond,
  input  logic [NUM_STATES*NUM_CHK-1:0]        cfgChkDis,
  input  logic [NUM_STATES*PTR_W-1:0]          cfgPtrVal,
  input  logic [PTR_W-1:0]                     instrPtr,
  input  logic                                 sigClk,
  input  logic                                 sigTxd,
  input  logic                                 sigRxd,
  input  logic                                 sigTimeout,
  input  logic [TS_W-1:0]                      timeNow,
  output logic [STATE_W-1:0]                   curState,
  output logic [TS_W-1:0]                      latchTime,
  output logic                                 latchEvent,
  output logic [OUT_N-1:0]                     trigOut
);
  logic [NUM_STATES-1:0] goMask;
  sslStrobe_t            strobe;
  stateIdx_t             phase;

  ssl_sense #(.PTR_W(PTR_W)) uSense (
    .clk        (clk),
    .rstN       (rstN),
    .instrPtr   (instrPtr),
    .sigClk     (sigClk),
    .sigTxd     (sigTxd),
    .sigRxd     (sigRxd),
    .sigTimeout (sigTimeout),
    .cfgCond    (cfgCond),
    .cfgChkDis  (cfgChkDis),
    .cfgPtrVal  (cfgPtrVal),
    .goMask     (goMask)
  );

  ssl_ctrl #(.DLY_W(DLY_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgEnable (cfgEnable),
    .cfgDelay  (cfgDelay),
    .goMask    (goMask),
    .curState  (phase),
    .strobe    (strobe)
  );

  ssl_datapath #(.TS_W(TS_W), .OUT_N(OUT_N), .SEL_W(SEL_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .timeNow    (timeNow),
    .cfgOutSel  (cfgOutSel),
    .latchTime  (latchTime),
    .latchEvent (latchEvent),
    .trigOut    (trigOut)
  );

  assign curState = phase;
endmodule

// File: rtl/ssl_checker.sv
module ssl_checker #(
  parameter int TS_W  = 32,
  parameter int OUT_N = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEnable,
  input logic [1:0]       curState,
  input logic [TS_W-1:0]  latchTime,
  input logic             latchEvent,
  input logic [OUT_N-1:0] trigOut
);
  // R2: the phase stays put or moves one step forward around the ring.
  assert_state_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgEnable |=> (curState == $past(curState)) || (curState == 2'($past(curState) + 2'd1)));

  // R10: a disabled unit sits in phase 0 and emits nothing.
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (curState == 2'd0) && !latchEvent && (trigOut == '0));

  // R8: the event flag lasts one cycle.
  assert_event_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    latchEvent |=> !latchEvent);

  // R8: exactly one trigger line with the event, none without it.
  assert_trig_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(trigOut) == (latchEvent ? 1 : 0));

  // R7: the captured time changes only together with an event.
  assert_time_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !latchEvent |-> $stable(latchTime));
endmodule

bind seq_stamp_latch ssl_checker #(.TS_W(TS_W), .OUT_N(OUT_N)) uChk (.*);

// File: tb/seq_stamp_latch_test.sv
module seq_stamp_latch_test;
  localparam int PTR_W = 8;
  localparam int TS_W  = 32;
  localparam int DLY_W = 16;
  localparam int OUT_N = 4;
  localparam int NT    = 4;
  localparam int NC    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic                    cfgEnable;
  logic [DLY_W-1:0]        cfgDelay;
  logic [1:0]              cfgOutSel;
  logic [NT*NC*2-1:0]      cfgCond;
  logic [NT*NC-1:0]        cfgChkDis;
  logic [NT*PTR_W-1:0]     cfgPtrVal;
  logic [PTR_W-1:0]        instrPtr;
  logic                    sigClk, sigTxd, sigRxd, sigTimeout;
  logic [TS_W-1:0]         tsCnt = 32'h1000_0000;
  logic [1:0]              curState;
  logic [TS_W-1:0]         latchTime;
  logic                    latchEvent;
  logic [OUT_N-1:0]        trigOut;

  always @(posedge clk) tsCnt <= tsCnt + 1;

  seq_stamp_latch #(.PTR_W(PTR_W), .TS_W(TS_W), .DLY_W(DLY_W), .OUT_N(OUT_N)) uut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDelay(cfgDelay),
    .cfgOutSel(cfgOutSel), .cfgCond(cfgCond), .cfgChkDis(cfgChkDis),
    .cfgPtrVal(cfgPtrVal), .instrPtr(instrPtr), .sigClk(sigClk), .sigTxd(sigTxd),
    .sigRxd(sigRxd), .sigTimeout(sigTimeout), .timeNow(tsCnt),
    .curState(curState), .latchTime(latchTime), .latchEvent(latchEvent),
    .trigOut(trigOut)
  );

  int nRun = 0;
  int nFail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setChk(input int t, input int c, input logic [1:0] code);
    cfgChkDis[t*NC + c]       = 1'b0;
    cfgCond[(t*NC + c)*2 +: 2] = code;
  endtask

  task automatic idle();
    cfgEnable  = 1'b0;
    cfgChkDis  = '1;
    cfgCond    = '0;
    cfgPtrVal  = '0;
    instrPtr   = '0;
    sigClk     = 1'b0;
    sigTxd     = 1'b0;
    sigRxd     = 1'b0;
    sigTimeout = 1'b0;
    tick();
    tick();
  endtask

  // Step 3 waits for the clock line high; steps 0..2 run freely.
  task automatic runToWrap();
    cfgEnable = 1'b1;
    tick(); tick(); tick();
    chk("R2 reach phase 3", 64'(curState), 64'd3);
    sigClk = 1'b1;
    tick();
    sigClk = 1'b0;
    chk("R2 wrap to phase 0", 64'(curState), 64'd0);
  endtask

  task automatic testReset();
    chk("R1 state", 64'(curState), 64'd0);
    chk("R1 latchTime", 64'(latchTime), 64'd0);
    chk("R1 event", 64'(latchEvent), 64'd0);
    chk("R1 trig", 64'(trigOut), 64'd0);
  endtask

  task automatic testFreeRun();
    logic [TS_W-1:0] expTs;
    idle();
    cfgDelay  = '0;
    cfgOutSel = 2'd2;
    cfgEnable = 1'b1;
    for (int k = 1; k < 4; k++) begin
      tick();
      chk("R2 R3 free step", 64'(curState), 64'(k));
    end
    tick();
    chk("R2 free wrap", 64'(curState), 64'd0);
    chk("R7 no event at wrap edge", 64'(latchEvent), 64'd0);
    expTs = tsCnt;
    tick();
    chk("R8 event D=0", 64'(latchEvent), 64'd1);
    chk("R7 time D=0", 64'(latchTime), 64'(expTs));
    chk("R8 trig sel2", 64'(trigOut), 64'b0100);
    tick();
    chk("R8 event one cycle", 64'(latchEvent), 64'd0);
    chk("R8 trig cleared", 64'(trigOut), 64'd0);
  endtask

  task automatic testLevel();
    idle();
    setChk(0, 1, 2'd0);
    cfgEnable = 1'b1;
    tick();
    chk("R4 clk low holds code0", 64'(curState), 64'd0);
    sigClk = 1'b1;
    tick();
    chk("R4 clk high passes code0", 64'(curState), 64'd1);
    idle();
    setChk(0, 2, 2'd1);
    sigTxd = 1'b1;
    cfgEnable = 1'b1;
    tick();
    chk("R4 txd high holds code1", 64'(curState), 64'd0);
    sigTxd = 1'b0;
    tick();
    chk("R4 txd low passes code1", 64'(curState), 64'd1);
  endtask

  task automatic testEdge();
    idle();
    setChk(0, 3, 2'd2);
    sigRxd = 1'b1;
    tick();
    cfgEnable = 1'b1;
    tick();
    chk("R5 steady high is no rise", 64'(curState), 64'd0);
    sigRxd = 1'b0;
    tick();
    chk("R5 fall is no rise", 64'(curState), 64'd0);
    sigRxd = 1'b1;
    tick();
    chk("R5 rise passes code2", 64'(curState), 64'd1);
    idle();
    setChk(0, 4, 2'd3);
    cfgEnable = 1'b1;
    tick();
    chk("R5 steady low is no fall", 64'(curState), 64'd0);
    sigTimeout = 1'b1;
    tick();
    chk("R5 rise is no fall", 64'(curState), 64'd0);
    sigTimeout = 1'b0;
    tick();
    chk("R5 fall passes code3", 64'(curState), 64'd1);
  endtask

  task automatic testPtr();
    idle();
    cfgPtrVal[0 +: 8] = 8'h5A;
    setChk(0, 0, 2'd0);
    instrPtr = 8'h10;
    cfgEnable = 1'b1;
    tick();
    chk("R6 code0 mismatch holds", 64'(curState), 64'd0);
    instrPtr = 8'h5A;
    tick();
    chk("R6 code0 match passes", 64'(curState), 64'd1);

    idle();
    cfgPtrVal[0 +: 8] = 8'h5A;
    setChk(0, 0, 2'd1);
    instrPtr = 8'h5A;
    cfgEnable = 1'b1;
    tick();
    chk("R6 code1 match holds", 64'(curState), 64'd0);
    instrPtr = 8'h5B;
    tick();
    chk("R6 code1 mismatch passes", 64'(curState), 64'd1);

    idle();
    cfgPtrVal[0 +: 8] = 8'h5A;
    setChk(0, 0, 2'd2);
    instrPtr = 8'h5A;
    tick();
    cfgEnable = 1'b1;
    tick();
    chk("R6 code2 staying inside holds", 64'(curState), 64'd0);
    instrPtr = 8'h11;
    tick();
    chk("R6 code2 outside holds", 64'(curState), 64'd0);
    instrPtr = 8'h5A;
    tick();
    chk("R6 code2 entry passes", 64'(curState), 64'd1);

    idle();
    cfgPtrVal[0 +: 8] = 8'h5A;
    setChk(0, 0, 2'd3);
    instrPtr = 8'h5A;
    tick();
    cfgEnable = 1'b1;
    tick();
    chk("R6 code3 inside holds", 64'(curState), 64'd0);
    instrPtr = 8'h5B;
    tick();
    chk("R6 code3 leaving passes", 64'(curState), 64'd1);
  endtask

  task automatic testAnd();
    idle();
    setChk(0, 1, 2'd0);
    setChk(0, 2, 2'd0);
    cfgEnable = 1'b1;
    sigClk = 1'b1; sigTxd = 1'b0;
    tick();
    chk("R3 one of two true holds", 64'(curState), 64'd0);
    sigClk = 1'b0; sigTxd = 1'b1;
    tick();
    chk("R3 other of two true holds", 64'(curState), 64'd0);
    sigClk = 1'b1;
    tick();
    chk("R3 both true passes", 64'(curState), 64'd1);
  endtask

  task automatic testDelay();
    logic [TS_W-1:0] expTs;
    idle();
    setChk(3, 1, 2'd0);
    cfgDelay  = 16'd5;
    cfgOutSel = 2'd1;
    runToWrap();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R7 no early event D=5", 64'(latchEvent), 64'd0);
    end
    expTs = tsCnt;
    tick();
    chk("R7 event at D+1", 64'(latchEvent), 64'd1);
    chk("R7 time at D+1", 64'(latchTime), 64'(expTs));
    chk("R8 trig sel1", 64'(trigOut), 64'b0010);
    tick();
    chk("R8 pulse ends", 64'(latchEvent), 64'd0);
  endtask

  task automatic testRetrigger();
    logic [TS_W-1:0] expTs;
    idle();
    setChk(3, 1, 2'd0);
    cfgDelay  = 16'd6;
    cfgOutSel = 2'd3;
    runToWrap();
    runToWrap();
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R9 old deadline gives no event", 64'(latchEvent), 64'd0);
    end
    expTs = tsCnt;
    tick();
    chk("R9 event after restart", 64'(latchEvent), 64'd1);
    chk("R9 time after restart", 64'(latchTime), 64'(expTs));
    chk("R8 trig sel3", 64'(trigOut), 64'b1000);
  endtask

  task automatic testDisable();
    logic [TS_W-1:0] heldTs;
    idle();
    cfgEnable = 1'b0;
    tick();
    chk("R10 disabled does not step", 64'(curState), 64'd0);
    setChk(3, 1, 2'd0);
    cfgDelay = 16'd3;
    runToWrap();
    heldTs = latchTime;
    tick();
    cfgEnable = 1'b0;
    tick();
    chk("R10 state forced 0", 64'(curState), 64'd0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R10 capture cancelled", 64'(latchEvent), 64'd0);
      chk("R10 time held", 64'(latchTime), 64'(heldTs));
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    #400000;
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cfgEnable = 1'b0; cfgDelay = '0; cfgOutSel = '0;
    cfgCond = '0; cfgChkDis = '1; cfgPtrVal = '0; instrPtr = '0;
    sigClk = 1'b0; sigTxd = 1'b0; sigRxd = 1'b0; sigTimeout = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testFreeRun();
    testLevel();
    testEdge();
    testPtr();
    testAnd();
    testDelay();
    testRetrigger();
    testDisable();
    summary();
    $finish;
  end
endmodule